// File: doc/BRIEF.md
# TLB Fill, Replace and Demap Controller

This block owns the write side of a fully associative translation buffer. Each slot holds a 64-bit tag and a 64-bit translation word. Three operations change the array. A fill places a new translation in a slot that the block chooses. An indexed write overwrites a slot named by the request address. A demap clears every valid slot whose page covers a given virtual address. The tag written by a fill or an indexed write always comes from the `tag_access` input, and the translation word comes from `op_data`.

When a slot that held a valid translation is overwritten or cleared, the block emits a one-cycle invalidation notice. The notice carries the old page's virtual base and its page-size code, so that downstream translation caches can flush that range. A read port lets the surrounding logic inspect any slot. Lookup is handled elsewhere.

In the translation word, bit 63 is the valid flag and bit 6 is the lock flag. Bits 62:61 hold the page-size code: 0 is 8 KB, 1 is 64 KB, 2 is 512 KB and 3 is 4 MB. The page mask for code s is all ones shifted left by 13+3·s bits. The `op_kind` encoding is 0 for fill, 1 for indexed write and 2 for demap.

Top module: `tlbm_engine`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, every slot reads as all zeros and `busy`, `done` and `inv_valid` are low.
- R2: A fill writes {`tag_access`, `op_data`} into the lowest-index slot whose valid bit 63 is clear. `done` is high with `done_ok`=1 in the cycle after the request is accepted.
- R3: If every slot is valid, a fill takes the lowest-index slot whose lock bit 6 is clear.
- R4: If every slot is both valid and locked, a fill changes no slot and emits no notice. It still pulses `done`, with `done_ok`=0.
- R5: An indexed write stores {`tag_access`, `op_data`} into the slot given by `op_addr[8:3]`, ignoring all other address bits. `done` is high with `done_ok`=1 in the next cycle.
- R6: A demap with address `op_data` clears to all zeros every slot that has bit 63 set and whose tag equals the address under that slot's own page mask. Invalid slots and slots that do not match are left unchanged.
- R7: In the cycle after a slot that held a valid translation is overwritten or cleared, `inv_valid` is high for one cycle. `inv_base` is the old tag ANDed with the old page mask, and `inv_size` is the old bits 62:61. Overwriting an invalid slot emits no notice. Demap notices appear in ascending slot order.
- R8: A demap holds `busy` high for exactly 64 cycles and scans one slot per cycle. It then drops `busy` and pulses `done` with `done_ok`=1. Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe, taken when not busy |
| op_kind | input | 2 | 0 fill, 1 indexed write, 2 demap |
| op_addr | input | 64 | Request address; bits 8:3 select the slot for an indexed write |
| op_data | input | 64 | Translation word for writes; virtual address for demap |
| tag_access | input | 64 | Tag written by fill and indexed write |
| busy | output | 1 | Demap scan in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | With done: 0 when a fill was dropped |
| inv_valid | output | 1 | Invalidation notice strobe |
| inv_base | output | 64 | Virtual base of the replaced page |
| inv_size | output | 2 | Page-size code of the replaced page |
| rd_idx | input | 6 | Slot to read |
| rd_tag | output | 64 | Tag of the slot selected by rd_idx |
| rd_tte | output | 64 | Translation word of the slot selected by rd_idx |

## Verification
The hardest states to reach are a full array with exactly two unlocked slots, followed by a full array with none unlocked. To get there, the bench fills all 64 slots through indexed writes. It first leaves slots 10 and 20 unlocked, and later relocks them. The demap test places a matching 8 KB page, a matching 64 KB page, a matching 4 MB page, a non-matching neighbour and a matching but invalid slot at scattered indices, so that one scan must emit three ordered notices. A fill is also injected in the middle of the scan to show that it is ignored.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

    localparam int WORD_W    = 64;
    localparam int VALID_BIT = 63;
    localparam int LOCK_BIT  = 6;
    localparam int SZ_LO     = 61;
    localparam int SZ_W      = 2;
    localparam int BASE_OFS  = 13;
    localparam int SZ_STEP   = 3;
    localparam int SLOT_LSB  = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SZ_W-1:0]   size_t;

    typedef struct packed {
        word_t tag;
        word_t tte;
    } entry_t;

    typedef struct packed {
        logic  valid;
        word_t base;
        size_t size;
    } notice_t;

    typedef enum logic [1:0] {
        OP_FILL  = 2'd0,
        OP_WRIDX = 2'd1,
        OP_DEMAP = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } state_e;

    function automatic word_t page_mask(size_t sz);
        word_t m;
        m = {WORD_W{1'b1}} << BASE_OFS;
        return m << (SZ_STEP * int'(sz));
    endfunction

    function automatic size_t size_of(entry_t e);
        return e.tte[SZ_LO +: SZ_W];
    endfunction

    function automatic logic covers(entry_t e, word_t va);
        word_t m;
        m = page_mask(size_of(e));
        return e.tte[VALID_BIT] && ((va & m) == (e.tag & m));
    endfunction

endpackage

// File: rtl/tlbm_store.sv
module tlbm_store
    import tlbm_pkg::*;
#(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [IW-1:0]  widx,
    input  entry_t         wdata,
    input  logic [IW-1:0]  ra_idx,
    output entry_t         ra,
    input  logic [IW-1:0]  rb_idx,
    output entry_t         rb,
    output logic [N-1:0]   valid_vec,
    output logic [N-1:0]   lock_vec
);

    entry_t mem [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign ra = mem[ra_idx];
    assign rb = mem[rb_idx];

    for (genvar g = 0; g < N; g++) begin : g_flags
        assign valid_vec[g] = mem[g].tte[VALID_BIT];
        assign lock_vec[g]  = mem[g].tte[LOCK_BIT];
    end

endmodule

// File: rtl/tlbm_victim.sv
module tlbm_victim #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  valid_vec,
    input  logic [N-1:0]  lock_vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    logic [N-1:0]  free_vec;
    logic [N-1:0]  open_vec;
    logic          free_hit;
    logic          open_hit;
    logic [IW-1:0] free_idx;
    logic [IW-1:0] open_idx;

    assign free_vec = ~valid_vec;
    assign open_vec = ~lock_vec;

    always_comb begin
        free_hit = 1'b0;
        free_idx = '0;
        open_hit = 1'b0;
        open_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                free_hit = 1'b1;
                free_idx = IW'(i);
            end
            if (open_vec[i]) begin
                open_hit = 1'b1;
                open_idx = IW'(i);
            end
        end
    end

    assign found = free_hit | open_hit;
    assign idx   = free_hit ? free_idx : open_idx;

endmodule

// File: rtl/tlbm_notice.sv
module tlbm_notice
    import tlbm_pkg::*;
(
    input  logic    fire,
    input  entry_t  old,
    output notice_t nt
);

    size_t sz;

    assign sz       = size_of(old);
    assign nt.valid = fire & old.tte[VALID_BIT];
    assign nt.base  = old.tag & page_mask(sz);
    assign nt.size  = sz;

endmodule

// File: rtl/tlbm_engine.sv
module tlbm_engine
    import tlbm_pkg::*;
#(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [1:0]    op_kind,
    input  logic [63:0]   op_addr,
    input  logic [63:0]   op_data,
    input  logic [63:0]   tag_access,
    output logic          busy,
    output logic          done,
    output logic          done_ok,
    output logic          inv_valid,
    output logic [63:0]   inv_base,
    output logic [1:0]    inv_size,
    input  logic [IW-1:0] rd_idx,
    output logic [63:0]   rd_tag,
    output logic [63:0]   rd_tte
);

    state_e        state;
    logic [IW-1:0] scan_idx;
    word_t         dm_addr;
    logic          done_q;
    logic          ok_q;
    notice_t       nt_q;

    logic [N-1:0]  valid_vec;
    logic [N-1:0]  lock_vec;
    logic          vic_found;
    logic [IW-1:0] vic_idx;

    op_e           kind;
    logic          accept;
    logic [IW-1:0] tgt_idx;
    logic          we;
    entry_t        wdata;
    entry_t        old;
    entry_t        rd_ent;
    notice_t       nt_d;

    assign kind   = op_e'(op_kind);
    assign accept = op_valid && (state == ST_IDLE);

    always_comb begin
        if (state == ST_SCAN) begin
            tgt_idx = scan_idx;
        end else if (kind == OP_FILL) begin
            tgt_idx = vic_idx;
        end else begin
            tgt_idx = op_addr[SLOT_LSB +: IW];
        end
    end

    always_comb begin
        we    = 1'b0;
        wdata = '0;
        if (state == ST_SCAN) begin
            we = covers(old, dm_addr);
        end else if (accept) begin
            case (kind)
                OP_FILL: begin
                    we    = vic_found;
                    wdata = '{tag: tag_access, tte: op_data};
                end
                OP_WRIDX: begin
                    we    = 1'b1;
                    wdata = '{tag: tag_access, tte: op_data};
                end
                default: we = 1'b0;
            endcase
        end
    end

    tlbm_store #(.N(N), .IW(IW)) i_store (
        .clk       (clk),
        .rst       (rst),
        .we        (we),
        .widx      (tgt_idx),
        .wdata     (wdata),
        .ra_idx    (rd_idx),
        .ra        (rd_ent),
        .rb_idx    (tgt_idx),
        .rb        (old),
        .valid_vec (valid_vec),
        .lock_vec  (lock_vec)
    );

    tlbm_victim #(.N(N), .IW(IW)) i_victim (
        .valid_vec (valid_vec),
        .lock_vec  (lock_vec),
        .found     (vic_found),
        .idx       (vic_idx)
    );

    tlbm_notice i_notice (
        .fire (we),
        .old  (old),
        .nt   (nt_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            scan_idx <= '0;
            dm_addr  <= '0;
            done_q   <= 1'b0;
            ok_q     <= 1'b0;
            nt_q     <= '0;
        end else begin
            done_q <= 1'b0;
            nt_q   <= nt_d;
            if (state == ST_SCAN) begin
                scan_idx <= scan_idx + 1'b1;
                if (scan_idx == IW'(N - 1)) begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                    ok_q   <= 1'b1;
                end
            end else if (accept) begin
                case (kind)
                    OP_FILL: begin
                        done_q <= 1'b1;
                        ok_q   <= vic_found;
                    end
                    OP_WRIDX: begin
                        done_q <= 1'b1;
                        ok_q   <= 1'b1;
                    end
                    OP_DEMAP: begin
                        state    <= ST_SCAN;
                        scan_idx <= '0;
                        dm_addr  <= op_data;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy      = (state == ST_SCAN);
    assign done      = done_q;
    assign done_ok   = ok_q;
    assign inv_valid = nt_q.valid;
    assign inv_base  = nt_q.base;
    assign inv_size  = nt_q.size;
    assign rd_tag    = rd_ent.tag;
    assign rd_tte    = rd_ent.tte;

endmodule

// File: rtl/tlbm_engine_chk.sv
module tlbm_engine_chk
    import tlbm_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [1:0]  op_kind,
    input logic        busy,
    input logic        done,
    input logic        done_ok,
    input logic        inv_valid,
    input logic [63:0] inv_base,
    input logic [1:0]  inv_size
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !inv_valid));

    assert_drop_only_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !done_ok) |-> ($past(op_valid) && !$past(busy) && ($past(op_kind) == 2'd0)));

    assert_notice_has_cause_R7: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> ($past(busy) || $past(op_valid)));

    assert_notice_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> ((inv_base & ~page_mask(inv_size)) == 64'd0));

    assert_busy_closes_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && done_ok));

    assert_busy_starts_on_demap_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(op_valid) && ($past(op_kind) == 2'd2)));

endmodule

bind tlbm_engine tlbm_engine_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .busy      (busy),
    .done      (done),
    .done_ok   (done_ok),
    .inv_valid (inv_valid),
    .inv_base  (inv_base),
    .inv_size  (inv_size)
);

// File: tb/test_tlbm_engine.sv
`timescale 1ns/1ps
module test_tlbm_engine;

    localparam logic [63:0] V  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] LK = 64'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [63:0] op_addr = '0;
    logic [63:0] op_data = '0;
    logic [63:0] tag_access = '0;
    logic [5:0]  rd_idx = '0;
    logic        busy, done, done_ok, inv_valid;
    logic [63:0] inv_base, rd_tag, rd_tte;
    logic [1:0]  inv_size;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tlbm_engine i_tlbm_engine (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .tag_access(tag_access),
        .busy(busy), .done(done), .done_ok(done_ok), .inv_valid(inv_valid),
        .inv_base(inv_base), .inv_size(inv_size), .rd_idx(rd_idx),
        .rd_tag(rd_tag), .rd_tte(rd_tte)
    );

    function automatic logic [63:0] sz(int s);
        return 64'(s) << 61;
    endfunction

    function automatic logic [63:0] pmask(int s);
        return ({64{1'b1}} << 13) << (3 * s);
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_entry(string req, int idx, logic [63:0] etag, logic [63:0] ette);
        rd_idx = 6'(idx);
        #1;
        chk(req, $sformatf("slot%0d tag", idx), rd_tag, etag);
        chk(req, $sformatf("slot%0d tte", idx), rd_tte, ette);
    endtask

    // issue one request; returns at the negedge after the accepting edge
    task automatic issue(logic [1:0] k, logic [63:0] a, logic [63:0] d, logic [63:0] t);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; op_addr = a; op_data = d; tag_access = t;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic chk_done(string req, logic ok, logic inv);
        chk(req, "done", 64'(done), 64'd1);
        chk(req, "done_ok", 64'(done_ok), 64'(ok));
        chk(req, "inv_valid", 64'(inv_valid), 64'(inv));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", 64'(busy), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "done", 64'(done), 64'd0);
        chk("R1", "inv_valid", 64'(inv_valid), 64'd0);
        chk_entry("R1", 0, 64'd0, 64'd0);
        chk_entry("R1", 63, 64'd0, 64'd0);
    endtask

    task automatic t_fill_free();
        issue(2'd0, '0, V | 64'h1111_0000, 64'h1000_2003);
        chk_done("R2", 1'b1, 1'b0);
        chk_entry("R2", 0, 64'h1000_2003, V | 64'h1111_0000);
        issue(2'd0, '0, V | sz(1) | 64'h2222_0000, 64'h1235_5A07);
        chk_done("R2", 1'b1, 1'b0);
        chk_entry("R2", 1, 64'h1235_5A07, V | sz(1) | 64'h2222_0000);
        // indexed write into invalid slot 5: no notice (R5, R7)
        issue(2'd1, 64'h28, V | LK | 64'h5555_0000, 64'h5000_0000);
        chk_done("R5", 1'b1, 1'b0);
        chk_entry("R5", 5, 64'h5000_0000, V | LK | 64'h5555_0000);
        chk_entry("R5", 4, 64'd0, 64'd0);
        for (int i = 2; i < 5; i++) begin
            issue(2'd0, '0, V | 64'(i), 64'(i) << 13);
        end
        issue(2'd0, '0, V | 64'h66, 64'h6666_0000);
        chk_done("R2", 1'b1, 1'b0);
        chk_entry("R2", 6, 64'h6666_0000, V | 64'h66);
        chk_entry("R2", 5, 64'h5000_0000, V | LK | 64'h5555_0000);
    endtask

    task automatic t_replace_notice();
        // bit 9 set, bits 8:3 = 1 -> slot 1
        issue(2'd1, 64'h208, V | 64'h7777_0000, 64'h7000_0000);
        chk_done("R7", 1'b1, 1'b1);
        chk("R7", "inv_base", inv_base, 64'h1235_0000);
        chk("R7", "inv_size", 64'(inv_size), 64'd1);
        chk_entry("R5", 1, 64'h7000_0000, V | 64'h7777_0000);
        @(negedge clk);
        chk("R7", "notice one cycle", 64'(inv_valid), 64'd0);
    endtask

    task automatic t_fill_unlocked();
        for (int i = 0; i < 64; i++) begin
            if (i == 10 || i == 20) begin
                issue(2'd1, 64'(i) << 3, V | sz(2) | 64'(i), 64'h0ABC_DE00 + 64'(i));
            end else begin
                issue(2'd1, 64'(i) << 3, V | LK | 64'(i), 64'(i) << 20);
            end
        end
        issue(2'd0, '0, V | 64'h99, 64'h9900_0000);
        chk_done("R3", 1'b1, 1'b1);
        chk("R3", "inv_base", inv_base, 64'h0ABC_DE0A & pmask(2));
        chk("R3", "inv_size", 64'(inv_size), 64'd2);
        chk_entry("R3", 10, 64'h9900_0000, V | 64'h99);
        chk_entry("R3", 20, 64'h0ABC_DE14, V | sz(2) | 64'd20);
    endtask

    task automatic t_fill_drop();
        issue(2'd1, 64'(10) << 3, V | LK | 64'd10, 64'(10) << 20);
        issue(2'd1, 64'(20) << 3, V | LK | 64'd20, 64'(20) << 20);
        issue(2'd0, '0, V | 64'hDEAD, 64'hBEEF_0000);
        chk_done("R4", 1'b0, 1'b0);
        chk_entry("R4", 0, 64'd0, V | LK);
        chk_entry("R4", 20, 64'(20) << 20, V | LK | 64'd20);
        chk_entry("R4", 63, 64'(63) << 20, V | LK | 64'd63);
    endtask

    task automatic t_demap();
        logic [63:0] d;
        logic [63:0] bases [3];
        logic [1:0]  sizes [3];
        int          n_inv;
        int          n_busy;
        int          n_done;
        int          cyc;
        d = 64'h40_0012_2100;
        t_reset();
        issue(2'd1, 64'(3) << 3,  V | 64'h3,           64'h40_0012_2005);
        issue(2'd1, 64'(7) << 3,  V | sz(1) | 64'h7,   64'h40_0012_0011);
        issue(2'd1, 64'(9) << 3,  V | 64'h9,           64'h40_0012_4000);
        issue(2'd1, 64'(12) << 3, V | sz(3) | 64'hC,   64'h40_0010_0000);
        issue(2'd1, 64'(15) << 3, 64'h42,              d);
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'd2; op_data = d;
        @(negedge clk);
        op_valid = 1'b0;
        n_inv = 0; n_busy = 0; n_done = 0; cyc = 0;
        while (n_done == 0 && cyc < 100) begin
            if (busy) n_busy++;
            if (inv_valid) begin
                if (n_inv < 3) begin
                    bases[n_inv] = inv_base;
                    sizes[n_inv] = inv_size;
                end
                n_inv++;
            end
            if (done) n_done++;
            if (cyc == 5) begin
                op_valid = 1'b1; op_kind = 2'd0; op_data = V | 64'hF; tag_access = 64'hF000;
            end else begin
                op_valid = 1'b0;
            end
            cyc++;
            if (n_done == 0) @(negedge clk);
        end
        chk("R8", "busy cycles", 64'(n_busy), 64'd64);
        chk("R8", "done_ok", 64'(done_ok), 64'd1);
        chk("R8", "busy after done", 64'(busy), 64'd0);
        chk("R7", "demap notice count", 64'(n_inv), 64'd3);
        if (n_inv >= 3) begin
            chk("R7", "notice0 base", bases[0], 64'h40_0012_2000);
            chk("R7", "notice1 base", bases[1], 64'h40_0012_0000);
            chk("R7", "notice2 base", bases[2], 64'h40_0000_0000);
            chk("R7", "notice2 size", 64'(sizes[2]), 64'd3);
        end
        chk_entry("R6", 3, 64'd0, 64'd0);
        chk_entry("R6", 7, 64'd0, 64'd0);
        chk_entry("R6", 12, 64'd0, 64'd0);
        chk_entry("R6", 9, 64'h40_0012_4000, V | 64'h9);
        chk_entry("R6", 15, d, 64'h42);
        chk_entry("R8", 0, 64'd0, 64'd0);
        issue(2'd0, '0, V | 64'hAB, 64'hAB_0000);
        chk_done("R2", 1'b1, 1'b0);
        chk_entry("R2", 0, 64'hAB_0000, V | 64'hAB);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_free();
        t_replace_notice();
        t_fill_unlocked();
        t_fill_drop();
        t_demap();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule